// File: doc/BRIEF.md
# Hub Reset Source Sequencer

This block merges the reset causes of a bridge or hub into two internal reset domains. The first cause is a power-good input. The second is an active-low hot-reset pin that has no timing relation to the core clock. The third is an in-band reset indication from the upstream serial link. A message decoder outside this block turns the link's reset-entry and reset-exit messages into one level. That level is high from entry until exit. The link has no reset wire of its own.

Each cause asserts its reset at once, with no clock needed. Release goes through a two-flop synchronizer and then a stretch counter, so every reset is held for a programmable number of extra core clocks. The cold reset follows power-good only and clears everything. The hot reset follows all three causes and resets the core logic, but it leaves the sticky error status alone. A link-down request goes to the upstream link while the hub is in reset for a local cause (power-good or the pin). It is not raised when the reset came from the link itself. A small sticky error register is included to show the difference between the two domains. Its bits are set by error events and are cleared only by a write-one-to-clear or by a cold reset.

Top module: `hub_rst_seq`

## Requirements
- R1: While `pwr_good_i` is low, `cold_rst_n_o` and `hot_rst_n_o` are low and `link_down_o` is high, with no clock edge needed for assertion.
- R2: A low level on `hot_rst_pin_n_i` drives `hot_rst_n_o` low and `link_down_o` high at once, and `cold_rst_n_o` stays high.
- R3: A high level on `link_rst_msg_i` drives `hot_rst_n_o` low at once, and leaves both `link_down_o` low and `cold_rst_n_o` high.
- R4: After the last cause of an output goes inactive between clock edges, that output is released on the rising edge numbered `hold_len_i` + 3 counted from that point. This covers `cold_rst_n_o` rising, `hot_rst_n_o` rising and `link_down_o` falling.
- R5: A 1 on bit i of `err_event_i` at a rising edge sets bit i of `sticky_err_o` while cold reset is inactive. Bits stay set with no further events.
- R6: With `err_clr_we_i` high, each bit written 1 in `err_clr_i` is cleared and bits written 0 are kept. An event on the same bit in the same cycle wins over the clear.
- R7: A hot reset from the pin or from the link message leaves `sticky_err_o` unchanged.
- R8: A cold reset clears all of `sticky_err_o` by the first rising edge while `cold_rst_n_o` is low.
- R9: `hot_rst_n_o` stays low for as long as `link_rst_msg_i` is high, whatever the stretch length. If the pin releases while the message is still high, `link_down_o` is released on its own schedule while hot reset stays held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pwr_good_i | input | 1 | Power-good, low means cold reset, asynchronous |
| hot_rst_pin_n_i | input | 1 | Hot-reset pin, active low, asynchronous |
| link_rst_msg_i | input | 1 | In-band reset level from the upstream link decoder, high between entry and exit |
| hold_len_i | input | HOLD_W | Extra core clocks each reset is held after its causes clear |
| err_event_i | input | N_ERR | Error event pulses, one per sticky bit |
| err_clr_we_i | input | 1 | Write strobe for the clear mask |
| err_clr_i | input | N_ERR | Write-one-to-clear mask |
| cold_rst_n_o | output | 1 | Cold reset, active low |
| hot_rst_n_o | output | 1 | Hot reset for core logic, active low |
| link_down_o | output | 1 | Request to take the upstream link down |
| sticky_err_o | output | N_ERR | Sticky error status |

## Verification
The bench measures release latency edge by edge for a non-zero stretch and for a zero stretch. A design with one synchronizer stage too few, or with an off-by-one in the counter, shows up there as a one-cycle error. It checks outputs just after each cause is applied and before any clock edge, which catches a design that asserts reset synchronously. It checks that a link-message reset never raises link-down and that a pin release during a held link message frees link-down but not hot reset, which catches a design that merges the causes wrongly. The sticky table covers a same-cycle event and clear, and clears of bits that were never set. Sticky contents are checked again after each hot reset, which catches a design that puts the sticky register in the hot domain.

// File: rtl/hub_rst_pkg.sv
// Package: shared constants and types for the hub reset sequencer.
// Assumes: three reset chains; their order is fixed by the top module.
package hub_rst_pkg;

    // Index of each reset chain in the chain array
    typedef enum logic [1:0] {
        CH_COLD  = 2'd0,   // power-good only
        CH_LOCAL = 2'd1,   // power-good and hot pin
        CH_ALL   = 2'd2    // power-good, hot pin and link message
    } chain_e;

    localparam int N_CHAIN  = 3;
    localparam int SYNC_LEN = 2;

endpackage

// File: rtl/rst_sync2.sv
// Module: reset synchronizer for one chain.
// Asserts (drives ok_o low) at once when clr_n goes low and needs no clock.
// Releases after SYNC_LEN rising edges of clk once clr_n is high.
// Assumes: clr_n may change at any time relative to clk.
module rst_sync2 #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic ok_o
);

    logic [SYNC_LEN-1:0] stage_q;

    // Shift a constant 1 through the stages; clear all stages asynchronously
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[SYNC_LEN-2:0], 1'b1};
        end
    end

    assign ok_o = stage_q[SYNC_LEN-1];

endmodule

// File: rtl/rst_stretch.sv
// Module: reset hold counter.
// Once src_ok goes high, counts core clocks and raises rel_o when the count
// reaches hold_len. Drops rel_o at once when src_ok drops.
// Assumes: src_ok is a synchronized level whose release is clock aligned.
module rst_stretch #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              src_ok,
    input  logic [HOLD_W-1:0] hold_len,
    output logic              rel_o
);

    logic [HOLD_W-1:0] cnt_q;
    logic              rel_q;

    // Count up to hold_len after release, then release; clear with the source
    always_ff @(posedge clk or negedge src_ok) begin
        if (!src_ok) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else if (!rel_q) begin
            if (cnt_q >= hold_len) begin
                rel_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign rel_o = rel_q;

endmodule

// File: rtl/sticky_err.sv
// Module: sticky error status register.
// Bits are set by events and cleared by write-one-to-clear. A set wins over a
// clear in the same cycle. The whole register clears while rst_n is low.
// Assumes: rst_n is the cold reset only, and is low for at least one edge.
module sticky_err #(
    parameter int N_ERR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ERR-1:0] event_i,
    input  logic             clr_we_i,
    input  logic [N_ERR-1:0] clr_i,
    output logic [N_ERR-1:0] status_o
);

    logic [N_ERR-1:0] status_q;
    logic [N_ERR-1:0] clr_mask;

    // Build the clear mask; it applies only on a write
    always_comb begin
        clr_mask = clr_we_i ? clr_i : '0;
    end

    // Hold, clear or set status bits; synchronous cold reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | event_i;
        end
    end

    assign status_o = status_q;

endmodule

// File: rtl/hub_rst_seq.sv
// Module: hub reset source sequencer (top).
// Builds three reset chains from raw causes. Each chain has an asynchronous
// clear, a synchronized release and a stretch counter:
//   cold  = power-good
//   local = power-good and hot pin   (drives link-down)
//   all   = every cause               (drives hot reset)
// The sticky error register lives in the cold domain only.
// Assumes: link_rst_msg_i is a level from an external message decoder that is
// high between reset entry and reset exit.
module hub_rst_seq #(
    parameter int HOLD_W = 8,
    parameter int N_ERR  = 4
) (
    input  logic              clk,
    input  logic              pwr_good_i,
    input  logic              hot_rst_pin_n_i,
    input  logic              link_rst_msg_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    input  logic [N_ERR-1:0]  err_event_i,
    input  logic              err_clr_we_i,
    input  logic [N_ERR-1:0]  err_clr_i,
    output logic              cold_rst_n_o,
    output logic              hot_rst_n_o,
    output logic              link_down_o,
    output logic [N_ERR-1:0]  sticky_err_o
);
    import hub_rst_pkg::*;

    logic [N_CHAIN-1:0] chain_clr_n;
    logic [N_CHAIN-1:0] chain_ok;
    logic [N_CHAIN-1:0] chain_rel;

    // Combine raw causes into the clear of each chain
    always_comb begin
        chain_clr_n[CH_COLD]  = pwr_good_i;
        chain_clr_n[CH_LOCAL] = pwr_good_i & hot_rst_pin_n_i;
        chain_clr_n[CH_ALL]   = pwr_good_i & hot_rst_pin_n_i & ~link_rst_msg_i;
    end

    // One synchronizer and one stretcher per chain
    for (genvar g = 0; g < N_CHAIN; g++) begin : g_chain
        rst_sync2 #(
            .SYNC_LEN (SYNC_LEN)
        ) u_sync (
            .clk   (clk),
            .clr_n (chain_clr_n[g]),
            .ok_o  (chain_ok[g])
        );

        rst_stretch #(
            .HOLD_W (HOLD_W)
        ) u_hold (
            .clk      (clk),
            .src_ok   (chain_ok[g]),
            .hold_len (hold_len_i),
            .rel_o    (chain_rel[g])
        );
    end

    assign cold_rst_n_o = chain_rel[CH_COLD];
    assign hot_rst_n_o  = chain_rel[CH_ALL];
    assign link_down_o  = ~chain_rel[CH_LOCAL];

    sticky_err #(
        .N_ERR (N_ERR)
    ) u_sticky (
        .clk      (clk),
        .rst_n    (cold_rst_n_o),
        .event_i  (err_event_i),
        .clr_we_i (err_clr_we_i),
        .clr_i    (err_clr_i),
        .status_o (sticky_err_o)
    );

endmodule

// File: rtl/hub_rst_seq_chk.sv
// Module: property checker for hub_rst_seq, attached by bind.
module hub_rst_seq_chk #(
    parameter int N_ERR = 4
) (
    input logic             clk,
    input logic             pwr_good_i,
    input logic             hot_rst_pin_n_i,
    input logic             link_rst_msg_i,
    input logic [N_ERR-1:0] err_event_i,
    input logic             err_clr_we_i,
    input logic             cold_rst_n_o,
    input logic             hot_rst_n_o,
    input logic             link_down_o,
    input logic [N_ERR-1:0] sticky_err_o
);

    // R1
    cold_implies_hot_chk: assert property (@(posedge clk) disable iff (!pwr_good_i)
        !cold_rst_n_o |-> !hot_rst_n_o);

    // R2
    pin_forces_hot_chk: assert property (@(posedge clk) disable iff (!pwr_good_i)
        !hot_rst_pin_n_i |-> (!hot_rst_n_o && link_down_o && cold_rst_n_o));

    // R3
    msg_forces_hot_chk: assert property (@(posedge clk) disable iff (!pwr_good_i)
        link_rst_msg_i |-> !hot_rst_n_o);

    // R3
    linkdown_in_reset_chk: assert property (@(posedge clk) disable iff (!pwr_good_i)
        link_down_o |-> !hot_rst_n_o);

    // R5
    event_sets_chk: assert property (@(posedge clk) disable iff (!pwr_good_i)
        $past(cold_rst_n_o) |-> ((sticky_err_o & $past(err_event_i)) == $past(err_event_i)));

    // R7
    no_write_keeps_chk: assert property (@(posedge clk) disable iff (!pwr_good_i)
        ($past(cold_rst_n_o) && !$past(err_clr_we_i)) |->
        ((sticky_err_o & $past(sticky_err_o)) == $past(sticky_err_o)));

    // R8
    cold_clears_chk: assert property (@(posedge clk) disable iff (!pwr_good_i)
        !$past(cold_rst_n_o) |-> (sticky_err_o == '0));

endmodule

bind hub_rst_seq hub_rst_seq_chk #(.N_ERR(N_ERR)) u_chk (
    .clk             (clk),
    .pwr_good_i      (pwr_good_i),
    .hot_rst_pin_n_i (hot_rst_pin_n_i),
    .link_rst_msg_i  (link_rst_msg_i),
    .err_event_i     (err_event_i),
    .err_clr_we_i    (err_clr_we_i),
    .cold_rst_n_o    (cold_rst_n_o),
    .hot_rst_n_o     (hot_rst_n_o),
    .link_down_o     (link_down_o),
    .sticky_err_o    (sticky_err_o)
);

// File: tb/hub_rst_seq_test.sv
module hub_rst_seq_test;
    localparam int HOLD_W = 8;
    localparam int N_ERR  = 4;
    localparam int NV     = 9;

    logic              clk = 1'b0;
    logic              pwr_good_i = 1'b0;
    logic              hot_rst_pin_n_i = 1'b1;
    logic              link_rst_msg_i = 1'b0;
    logic [HOLD_W-1:0] hold_len_i = 8'd3;
    logic [N_ERR-1:0]  err_event_i = '0;
    logic              err_clr_we_i = 1'b0;
    logic [N_ERR-1:0]  err_clr_i = '0;
    logic              cold_rst_n_o, hot_rst_n_o, link_down_o;
    logic [N_ERR-1:0]  sticky_err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    hub_rst_seq #(.HOLD_W(HOLD_W), .N_ERR(N_ERR)) uut (
        .clk(clk), .pwr_good_i(pwr_good_i), .hot_rst_pin_n_i(hot_rst_pin_n_i),
        .link_rst_msg_i(link_rst_msg_i), .hold_len_i(hold_len_i),
        .err_event_i(err_event_i), .err_clr_we_i(err_clr_we_i), .err_clr_i(err_clr_i),
        .cold_rst_n_o(cold_rst_n_o), .hot_rst_n_o(hot_rst_n_o),
        .link_down_o(link_down_o), .sticky_err_o(sticky_err_o));

    // Sticky vectors: {event, clear write, clear mask, expected status}
    typedef struct packed {
        logic [N_ERR-1:0] ev;
        logic             we;
        logic [N_ERR-1:0] clr;
        logic [N_ERR-1:0] exp;
    } vec_t;
    localparam vec_t VECS [NV] = '{
        '{4'b0001, 1'b0, 4'b0000, 4'b0001},
        '{4'b0100, 1'b0, 4'b0000, 4'b0101},
        '{4'b0000, 1'b0, 4'b0000, 4'b0101},
        '{4'b0000, 1'b1, 4'b0001, 4'b0100},
        '{4'b0000, 1'b1, 4'b1010, 4'b0100},
        '{4'b0010, 1'b1, 4'b0010, 4'b0110},
        '{4'b1000, 1'b0, 4'b1111, 4'b1110},
        '{4'b0000, 1'b1, 4'b1111, 4'b0000},
        '{4'b1011, 1'b0, 4'b0000, 4'b1011}
    };

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Count rising edges until the selected output is released (0 cold, 1 hot, 2 link-down)
    task automatic measure(input int sel, output int n);
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if ((sel == 0 && cold_rst_n_o) || (sel == 1 && hot_rst_n_o) ||
                (sel == 2 && !link_down_o)) break;
        end
    endtask

    initial begin
        #2000000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int n;
        #1;
        // R1: reset state with power-good low
        chk("R1 cold", cold_rst_n_o, 0);
        chk("R1 hot", hot_rst_n_o, 0);
        chk("R1 linkdown", link_down_o, 1);
        repeat (3) @(negedge clk);
        chk("R8 sticky at reset", sticky_err_o, 0);
        // R4: release with hold 3
        pwr_good_i = 1'b1;
        measure(0, n);
        chk("R4 cold release edges", n, 6);
        chk("R4 hot with cold", hot_rst_n_o, 1);
        chk("R4 linkdown with cold", link_down_o, 0);

        // R5 R6: table walk
        foreach (VECS[i]) begin
            @(negedge clk);
            err_event_i = VECS[i].ev; err_clr_we_i = VECS[i].we; err_clr_i = VECS[i].clr;
            @(negedge clk);
            err_event_i = '0; err_clr_we_i = 1'b0; err_clr_i = '0;
            chk($sformatf("R5 R6 vector %0d", i), sticky_err_o, VECS[i].exp);
        end

        // R2: pin reset
        @(negedge clk);
        hot_rst_pin_n_i = 1'b0;
        #1;
        chk("R2 hot", hot_rst_n_o, 0);
        chk("R2 linkdown", link_down_o, 1);
        chk("R2 cold", cold_rst_n_o, 1);
        repeat (4) @(negedge clk);
        chk("R7 sticky after pin", sticky_err_o, 4'b1011);
        hot_rst_pin_n_i = 1'b1;
        measure(1, n);
        chk("R4 hot release edges", n, 6);
        chk("R4 linkdown with hot", link_down_o, 0);

        // R3 R9: link message with hold 0
        hold_len_i = 8'd0;
        link_rst_msg_i = 1'b1;
        #1;
        chk("R3 hot", hot_rst_n_o, 0);
        chk("R3 linkdown", link_down_o, 0);
        chk("R3 cold", cold_rst_n_o, 1);
        repeat (20) @(negedge clk);
        chk("R9 hot held", hot_rst_n_o, 0);
        chk("R3 linkdown held", link_down_o, 0);
        link_rst_msg_i = 1'b0;
        measure(1, n);
        chk("R4 hot release hold0", n, 3);
        chk("R7 sticky after msg", sticky_err_o, 4'b1011);

        // R9: pin and message overlap, pin released first
        @(negedge clk);
        hot_rst_pin_n_i = 1'b0;
        link_rst_msg_i = 1'b1;
        repeat (3) @(negedge clk);
        hot_rst_pin_n_i = 1'b1;
        measure(2, n);
        chk("R9 linkdown release", n, 3);
        chk("R9 hot still held", hot_rst_n_o, 0);
        link_rst_msg_i = 1'b0;
        measure(1, n);
        chk("R4 hot after overlap", n, 3);

        // R8: cold reset clears sticky
        @(negedge clk);
        pwr_good_i = 1'b0;
        #1;
        chk("R1 cold async", cold_rst_n_o, 0);
        @(negedge clk);
        chk("R8 sticky cleared", sticky_err_o, 0);
        pwr_good_i = 1'b1;
        measure(0, n);
        chk("R4 cold release hold0", n, 3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule